// File: doc/BRIEF.md
# Guard-Cell Cell-Averaging CFAR Detector

This block applies an adaptive detection threshold to a stream of squared-envelope values. The values come from one Doppler channel at a time and are ordered by range. For every range cell, the block totals a window of neighbouring cells. This total leaves out the cell being judged and the single cell on each side of it. The block then compares the cell's power against the total scaled by a programmable false-alarm factor. Each result carries a detect flag, the cell's power and the reference total.

The reference window reaches eight cells to each side of the cell under test. One guard cell on each side is skipped, so fourteen cells feed the total. The total is kept as a running sum. On each accepted sample it adds the cells that enter the reference set and subtracts the cells that leave it.

The compare is made without a divider. A cell detects when `power * 14 * 256` is strictly greater than `alpha * refsum`. Here `alpha` is an unsigned factor with eight fraction bits. Lines in channel 0 are the zero-velocity channel, which is handled elsewhere, so they never detect. A cell whose left window would reach past the start of the line is reported with an edge flag and never detects.

Top module: `cfar_gc`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `out_detect` are 0.
- R2: Let a sample be accepted at line index k, with k >= 8. Two clock edges later there is exactly one result with `out_valid` high, for cell k-8, and `out_power` equals that cell's sample. Samples with index below 8 produce no result, so a line of n samples yields n-8 results.
- R3: `out_refsum` is the sum of the samples at distance 2 through 8 on both sides of the cell. A left-side position before index 0 counts as 0. The cell itself and its two direct neighbours are not included.
- R4: `alpha` is a 12-bit unsigned value with 8 fraction bits (256 means 1.0), sampled one edge after the cell's last window sample. Outside the edge and zero-channel cases, `out_detect` is 1 exactly when `power*14*256 > alpha*refsum`.
- R5: Results for cells 0 to 7 have `out_edge` = 1 and `out_detect` = 0; every later cell has `out_edge` = 0.
- R6: A line whose first sample carries `in_chan` = 0 never raises `out_detect`. The channel is latched from the sample that has `in_first` set.
- R7: A sample with `in_first` set starts a new line at index 0. No sample of an earlier line enters any total of the new line, even when the new line follows without a gap.
- R8: Cycles with `in_valid` low are ignored: `in_power` and `in_first` have no effect then, and idle cycles inside a line do not change any result value.
- R9: When `power*14*256` equals `alpha*refsum`, `out_detect` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_first | input | 1 | Marks the first range cell of a line |
| in_chan | input | CHW | Doppler channel number, taken with `in_first` |
| in_power | input | PW | Squared-envelope sample |
| alpha | input | AW | False-alarm factor, unsigned with FRAC fraction bits |
| out_valid | output | 1 | Result strobe |
| out_detect | output | 1 | Cell exceeds its threshold |
| out_edge | output | 1 | Cell lies too close to the start of the line for a full window |
| out_power | output | PW | Power of the reported cell |
| out_refsum | output | SW | Sum of the fourteen reference cells |

## Verification
Two things can happen on the same edge: a new line restarts the window, and the last result of the previous line is still being scaled and compared. The bench provokes this by driving one line directly after another, with `in_first` on the cycle right after the old line's final sample. The old line's first line holds strong values and the new line holds weak ones. The bench then judges both lines independently. The old line's final result must match its own window, and the new line's totals must contain nothing from the old one. Idle gaps and garbage power during idle cycles are mixed into other lines to show that the pipeline advances only on accepted samples.

// File: rtl/cfar_gc.sv
module cfar_gc #(
  parameter int PW    = 16,
  parameter int AW    = 12,
  parameter int FRAC  = 8,
  parameter int HALF  = 8,
  parameter int GUARD = 1,
  parameter int CHW   = 3,
  parameter int NCELL = 512
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  input  logic                                   in_first,
  input  logic [CHW-1:0]                         in_chan,
  input  logic [PW-1:0]                          in_power,
  input  logic [AW-1:0]                          alpha,
  output logic                                   out_valid,
  output logic                                   out_detect,
  output logic                                   out_edge,
  output logic [PW-1:0]                          out_power,
  output logic [PW+$clog2(2*(HALF-GUARD)+1)-1:0] out_refsum
);
  localparam int NREF  = 2 * (HALF - GUARD);
  localparam int DEPTH = 2 * HALF + 1;
  localparam int SW    = PW + $clog2(NREF + 1);
  localparam int IW    = $clog2(NCELL + 1);
  localparam int CW    = SW + AW + FRAC;
  localparam logic [IW-1:0] IMAX = '1;

  logic [PW-1:0]  tap [DEPTH];
  logic [SW-1:0]  rsum;
  logic [IW-1:0]  idx, nidx;
  logic [CHW-1:0] chan;
  logic           v0, e0;
  logic [CW-1:0]  lhs, rhs;

  assign nidx = in_first ? '0 : (idx == IMAX ? idx : idx + 1'b1);
  assign lhs  = (CW'(tap[HALF]) * CW'(NREF)) << FRAC;
  assign rhs  = CW'(alpha) * CW'(rsum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0   <= 1'b0;
      e0   <= 1'b0;
      idx  <= '0;
      chan <= '0;
      rsum <= '0;
      for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
    end else begin
      v0 <= in_valid && (nidx >= IW'(HALF));
      e0 <= nidx < IW'(2 * HALF);
      if (in_valid) begin
        idx    <= nidx;
        tap[0] <= in_power;
        for (int i = 1; i < DEPTH; i++) tap[i] <= in_first ? '0 : tap[i-1];
        if (in_first) begin
          chan <= in_chan;
          rsum <= SW'(in_power);
        end else begin
          rsum <= rsum + SW'(in_power) - SW'(tap[HALF-GUARD-1])
                + SW'(tap[HALF+GUARD]) - SW'(tap[2*HALF]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_detect <= 1'b0;
      out_edge   <= 1'b0;
      out_power  <= '0;
      out_refsum <= '0;
    end else begin
      out_valid  <= v0;
      out_edge   <= v0 && e0;
      out_detect <= v0 && !e0 && (chan != '0) && (lhs > rhs);
      if (v0) begin
        out_power  <= tap[HALF];
        out_refsum <= rsum;
      end
    end
  end
endmodule

// File: rtl/cfar_gc_chk.sv
module cfar_gc_chk #(
  parameter int PW    = 16,
  parameter int AW    = 12,
  parameter int FRAC  = 8,
  parameter int HALF  = 8,
  parameter int GUARD = 1,
  parameter int CHW   = 3,
  parameter int NCELL = 512
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   in_valid,
  input logic                                   in_first,
  input logic [AW-1:0]                          alpha,
  input logic                                   out_valid,
  input logic                                   out_detect,
  input logic                                   out_edge,
  input logic [PW-1:0]                          out_power,
  input logic [PW+$clog2(2*(HALF-GUARD)+1)-1:0] out_refsum
);
  localparam int NREF = 2 * (HALF - GUARD);
  localparam int SW   = PW + $clog2(NREF + 1);
  localparam int CW   = SW + AW + FRAC;

  logic [AW-1:0] alpha_d;
  logic [CW-1:0] c_lhs, c_rhs;
  always_ff @(posedge clk) alpha_d <= alpha;
  assign c_lhs = (CW'(out_power) * CW'(NREF)) << FRAC;
  assign c_rhs = CW'(alpha_d) * CW'(out_refsum);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));
  p_first_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first) |-> ##2 !out_valid);
  p_detect_strict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_detect |-> (out_valid && (c_lhs > c_rhs)));
  p_edge_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_edge |-> (out_valid && !out_detect));
endmodule

bind cfar_gc cfar_gc_chk #(.PW(PW), .AW(AW), .FRAC(FRAC), .HALF(HALF),
  .GUARD(GUARD), .CHW(CHW), .NCELL(NCELL)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
  .alpha(alpha), .out_valid(out_valid), .out_detect(out_detect),
  .out_edge(out_edge), .out_power(out_power), .out_refsum(out_refsum));

// File: tb/cfar_gc_tb.sv
module cfar_gc_tb;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_first = 0;
  logic [2:0]  in_chan = 0;
  logic [15:0] in_power = 0;
  logic [11:0] alpha = 0;
  logic        out_valid, out_detect, out_edge;
  logic [15:0] out_power;
  logic [19:0] out_refsum;

  cfar_gc u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_chan(in_chan), .in_power(in_power), .alpha(alpha), .out_valid(out_valid),
    .out_detect(out_detect), .out_edge(out_edge), .out_power(out_power),
    .out_refsum(out_refsum));

  always #10 clk = ~clk;

  int cyc = 0, total = 0, bad = 0, nres = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ls [2][64];
  int tin [2][64];
  int rp [256], rs [256], rt [256];
  bit rd [256], re [256];
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) if (rst_n && out_valid && nres < 256) begin
    rp[nres] = out_power; rs[nres] = out_refsum; rd[nres] = out_detect;
    re[nres] = out_edge; rt[nres] = cyc; nres++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic drive_line(input int L, input int n, input int ch, input int al, input int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1; in_first = (k == 0); in_chan = ch[2:0];
      in_power = ls[L][k][15:0]; alpha = al[11:0]; tin[L][k] = cyc;
      if (gap > 0) begin
        @(negedge clk);
        in_valid = 0; in_first = 1; in_power = 16'hFFFF;
        repeat (gap - 1) @(negedge clk);
        in_first = 0;
      end
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 0; in_first = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_line(input int L, input int n, input int base, input int ch,
                            input int al, input string dtag);
    for (int c = 0; c + 8 < n; c++) begin
      int r = base + c;
      longint sum = 0;
      bit edg, det;
      for (int d = 2; d <= 8; d++) begin
        sum += ls[L][c+d];
        if (c - d >= 0) sum += ls[L][c-d];
      end
      edg = (c < 8);
      det = !edg && ch != 0 && (longint'(ls[L][c]) * 14 * 256 > longint'(al) * sum);
      chk(rp[r] == ls[L][c], "R2 power", rp[r], ls[L][c]);
      chk(rt[r] == tin[L][c+8] + 2, "R2 latency", rt[r], tin[L][c+8] + 2);
      chk(rs[r] == sum, "R3 refsum", rs[r], sum);
      chk(re[r] == edg, "R5 edge", re[r], edg);
      chk(rd[r] == det, {dtag, " detect"}, rd[r], det);
    end
  endtask

  task automatic run_one(input int n, input int ch, input int al, input int gap, input string dtag);
    nres = 0;
    drive_line(0, n, ch, al, gap);
    idle(4);
    chk(nres == n - 8, "R2 count", nres, n - 8);
    check_line(0, n, 0, ch, al, dtag);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 0, "R1 valid", out_valid, 0);
    chk(out_detect == 0, "R1 detect", out_detect, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 valid after release", out_valid, 0);
  endtask

  task automatic t_flat_r9;
    for (int k = 0; k < 32; k++) ls[0][k] = 100;
    run_one(32, 3, 256, 0, "R9");
  endtask

  task automatic t_target_r4;
    for (int k = 0; k < 40; k++) ls[0][k] = 100;
    ls[0][3] = 5000; ls[0][15] = 1000; ls[0][16] = 900; ls[0][30] = 420;
    run_one(40, 5, 768, 0, "R4");
  endtask

  task automatic t_gaps_r8;
    for (int k = 0; k < 36; k++) ls[0][k] = 80 + (k % 5) * 7;
    ls[0][20] = 2000;
    run_one(36, 2, 1024, 2, "R8");
  endtask

  task automatic t_zero_chan_r6;
    for (int k = 0; k < 30; k++) ls[0][k] = 50;
    ls[0][12] = 60000; ls[0][20] = 40000;
    run_one(30, 0, 256, 0, "R6");
  endtask

  task automatic t_back2back_r7;
    for (int k = 0; k < 24; k++) ls[0][k] = 5000 + k;
    for (int k = 0; k < 28; k++) ls[1][k] = 10;
    ls[1][9] = 30; ls[1][14] = 12;
    nres = 0;
    drive_line(0, 24, 4, 512, 0);
    drive_line(1, 28, 6, 512, 0);
    idle(4);
    chk(nres == 16 + 20, "R7 count", nres, 36);
    check_line(0, 24, 0, 4, 512, "R7");
    check_line(1, 28, 16, 6, 512, "R7");
  endtask

  task automatic t_random_r4(input int al);
    for (int k = 0; k < 48; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ls[0][k] = (k % 9 == 4) ? int'(lfsr) : int'(lfsr & 16'h03FF);
    end
    run_one(48, 7, al, k_gap(al), "R4");
  endtask

  function automatic int k_gap(input int al);
    return (al % 3);
  endfunction

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    idle(2);
    t_flat_r9();
    t_target_r4();
    t_gaps_r8();
    t_zero_chan_r6();
    t_back2back_r7();
    t_random_r4(0);
    t_random_r4(300);
    t_random_r4(4095);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule